// File: doc/BRIEF.md
# Card-Host Write FIFO Start Controller

This block buffers outgoing data words on the transmit side of a memory-card host. Host logic pushes words into a FIFO. The card-side serializer pulls them out. The block decides when the serializer may begin a block write. In threshold mode, the start point depends on how the programmed block length compares with the FIFO depth. A long block starts once half the FIFO is filled. A medium block starts at a quarter fill. A short block waits until every one of its words is buffered. In immediate mode, the first buffered word releases the start.

Pushing into a full FIFO is an overflow, and pulling from an empty FIFO while a transfer runs is an underflow. Either one raises a single flow-error flag. A configuration bit chooses how that flag clears: either the next command-start pulse clears it, or a status-read strobe does. The configuration register holds four fields. It ignores writes while a write-protect input is high.

Both data ports use valid/ready. On the host side, `in_ready` is low when the FIFO is full. A source should hold its word until `in_ready` is high. A word offered while `in_ready` is low is dropped and counted as an overflow. On the card side, `out_valid` is high only while the start is asserted and the FIFO holds data. A word moves when `out_valid` and `out_ready` are both high. While `out_ready` is low, the head word and `out_valid` stay put. If `out_ready` is raised while the start is asserted and the FIFO is empty, that is an underflow.

Top module: `wfifo_start_ctrl`

## Requirements
- R1: In threshold mode (config bit 0 = 0), when 4*blk_len >= 3*DEPTH, `xfer_start` rises only after the fill reaches DEPTH/2. It is high by the second clock after that fill is reached.
- R2: In threshold mode, when 2*DEPTH <= 4*blk_len < 3*DEPTH, `xfer_start` rises once the fill reaches DEPTH/4 and not before.
- R3: In threshold mode, when 4*blk_len < 2*DEPTH, `xfer_start` rises only after blk_len words have been accepted since the last `cmd_start`, even if the fill already exceeds DEPTH/4.
- R4: In immediate mode (config bit 0 = 1), `xfer_start` rises once the FIFO holds at least one word.
- R5: Once high, `xfer_start` stays high until blk_len words have left through the card port, and then it falls. After that, it rises again only after a new `cmd_start` pulse. A `cmd_start` pulse clears `xfer_start` and restarts both word tallies.
- R6: A host word offered when the FIFO is full is dropped. The fill count is unchanged and `flow_err` is set.
- R7: `out_ready` high while `xfer_start` is high and the FIFO is empty sets `flow_err` one cycle later.
- R8: With the clear policy at 0 (config bit 4 = 0), `flow_err` ignores `stat_rd` and clears on the next `cmd_start`.
- R9: With the clear policy at 1 (config bit 4 = 1), `flow_err` ignores `cmd_start` and clears on the next `stat_rd`.
- R10: An overflow or underflow in the same cycle as a clearing `cmd_start` or `stat_rd` leaves `flow_err` set.
- R11: The configuration fields sit at bit 0 (immediate mode), bit 4 (clear policy), bit 8 (high-speed select) and bit 12 (last-block sync). All other bits read as zero, and the register resets to zero.
- R12: While `cfg_wp_en` is high, configuration writes are ignored.
- R13: Words leave in the order they were accepted. `in_ready` is low exactly when the FIFO is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_data | input | REG_W | Configuration write value |
| cfg_wp_en | input | 1 | Write-protect enable for the configuration register |
| cfg_rd_data | output | REG_W | Configuration readback |
| cmd_start | input | 1 | New data-command pulse |
| blk_len | input | LEN_W | Block length in words |
| stat_rd | input | 1 | Status-read strobe |
| in_valid | input | 1 | Host word valid |
| in_ready | output | 1 | FIFO can accept a word |
| in_data | input | DW | Host word |
| out_valid | output | 1 | Card-side word available |
| out_ready | input | 1 | Card side takes a word |
| out_data | output | DW | Head-of-FIFO word |
| xfer_start | output | 1 | Block write may proceed |
| flow_err | output | 1 | Overflow/underflow flag |
| fill_count | output | $clog2(DEPTH)+1 | Words held in the FIFO |

## Verification
The hardest case to reach is an error that lands in the same cycle as a clear. An underflow needs the start to be held high over an empty FIFO. The bench sets this up by making a block longer than the words it supplies, then draining every word, so the start stays armed. It then raises `out_ready` in the same cycle as `stat_rd` under one policy, and in the same cycle as `cmd_start` under the other. The block-length classes are probed right at their boundary lengths (24 and 16 words for a depth of 32). A short block is pushed past the quarter fill to show that it still waits for its whole length.

// File: rtl/wfs_pkg.sv
package wfs_pkg;
  localparam int CFG_IMM_BIT  = 0;
  localparam int CFG_ERR_BIT  = 4;
  localparam int CFG_HS_BIT   = 8;
  localparam int CFG_LAST_BIT = 12;

  typedef struct packed {
    logic last_sync;
    logic hs_sel;
    logic err_by_status;
    logic imm_start;
  } wfs_cfg_t;

  typedef enum logic [1:0] {
    LEN_HALF    = 2'd0,
    LEN_QUARTER = 2'd1,
    LEN_WHOLE   = 2'd2
  } len_class_e;
endpackage

// File: rtl/wfs_cfg_reg.sv
module wfs_cfg_reg
  import wfs_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wp_en,
  input  logic [REG_W-1:0] wr_data,
  output wfs_cfg_t         cfg,
  output logic [REG_W-1:0] rd_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (wr_en && !wp_en) begin
      cfg.imm_start     <= wr_data[CFG_IMM_BIT];
      cfg.err_by_status <= wr_data[CFG_ERR_BIT];
      cfg.hs_sel        <= wr_data[CFG_HS_BIT];
      cfg.last_sync     <= wr_data[CFG_LAST_BIT];
    end
  end

  always_comb begin
    rd_data               = '0;
    rd_data[CFG_IMM_BIT]  = cfg.imm_start;
    rd_data[CFG_ERR_BIT]  = cfg.err_by_status;
    rd_data[CFG_HS_BIT]   = cfg.hs_sel;
    rd_data[CFG_LAST_BIT] = cfg.last_sync;
  end

  // R12: a protected write leaves every field untouched
  p_wp_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wp_en) |=> $stable(cfg));

  // R11: an open write lands the mode and policy bits from their positions
  p_cfg_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wp_en) |=> (cfg.imm_start == $past(wr_data[CFG_IMM_BIT])) &&
                          (cfg.err_by_status == $past(wr_data[CFG_ERR_BIT])));
endmodule

// File: rtl/wfs_fifo.sv
module wfs_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_req,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_req,
  output logic [DW-1:0] rd_data,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty,
  output logic          wr_fire,
  output logic          rd_fire,
  output logic          ovf
);
  localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  assign full    = (count == FULL_CNT);
  assign empty   = (count == '0);
  assign wr_fire = wr_req && !full;
  assign rd_fire = rd_req && !empty;
  assign ovf     = wr_req && full;
  assign rd_data = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (wr_fire) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_fire) wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + AW'(1);
      if (rd_fire) rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + AW'(1);
      case ({wr_fire, rd_fire})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  // R6: a push into a full FIFO with no pull leaves the fill unchanged
  p_full_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && full && !rd_req) |=> $stable(count));

  // R6: the fill never exceeds the depth
  p_fill_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_CNT);
endmodule

// File: rtl/wfs_start_ctl.sv
module wfs_start_ctl
  import wfs_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int LEN_W = 12,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             imm,
  input  logic [LEN_W-1:0] blk_len,
  input  logic             cmd_start,
  input  logic [CW-1:0]    fill,
  input  logic             wr_fire,
  input  logic             rd_fire,
  output logic             start
);
  localparam int EW = LEN_W + 2;
  localparam logic [EW-1:0] LIM_3Q    = EW'(3 * DEPTH);
  localparam logic [EW-1:0] LIM_HALF  = EW'(2 * DEPTH);
  localparam logic [CW-1:0] LVL_HALF  = CW'(DEPTH / 2);
  localparam logic [CW-1:0] LVL_QTR   = CW'(DEPTH / 4);

  logic [LEN_W-1:0] wr_total, rd_total;
  logic [EW-1:0]    len4;
  logic [LEN_W:0]   rd_next;
  len_class_e       cls;
  logic             armed, go, rd_last;

  assign len4    = EW'(blk_len) << 2;
  assign rd_next = {1'b0, rd_total} + (LEN_W+1)'(1);
  assign rd_last = rd_fire && (rd_next == {1'b0, blk_len});

  always_comb begin
    if (len4 >= LIM_3Q)        cls = LEN_HALF;
    else if (len4 >= LIM_HALF) cls = LEN_QUARTER;
    else                       cls = LEN_WHOLE;
  end

  always_comb begin
    if (imm) begin
      go = (fill != '0);
    end else begin
      case (cls)
        LEN_HALF:    go = (fill >= LVL_HALF);
        LEN_QUARTER: go = (fill >= LVL_QTR);
        default:     go = (blk_len != '0) && (wr_total >= blk_len);
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      start    <= 1'b0;
      wr_total <= '0;
      rd_total <= '0;
    end else if (cmd_start) begin
      armed    <= 1'b1;
      start    <= 1'b0;
      rd_total <= '0;
      wr_total <= wr_fire ? LEN_W'(1) : '0;
    end else begin
      if (wr_fire && (wr_total != '1)) wr_total <= wr_total + LEN_W'(1);
      if (rd_fire) rd_total <= rd_total + LEN_W'(1);
      if (start && rd_last) begin
        start <= 1'b0;
        armed <= 1'b0;
      end else if (armed && !start && go) begin
        start <= 1'b1;
      end
    end
  end

  // R1: a long block starts only from a half-full FIFO
  p_half_lvl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(start) && !$past(imm) && ($past(cls) == LEN_HALF)) |-> ($past(fill) >= LVL_HALF));

  // R2: a medium block starts only from a quarter-full FIFO
  p_qtr_lvl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(start) && !$past(imm) && ($past(cls) == LEN_QUARTER)) |-> ($past(fill) >= LVL_QTR));

  // R3: a short block starts only after the whole block was accepted
  p_whole_blk_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(start) && !$past(imm) && ($past(cls) == LEN_WHOLE)) |-> ($past(wr_total) >= $past(blk_len)));

  // R4: immediate mode never starts from an empty FIFO
  p_imm_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(start) && $past(imm)) |-> ($past(fill) != '0));

  // R5: the start holds while nothing is consumed and no command arrives
  p_start_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !rd_fire && !cmd_start) |=> start);
endmodule

// File: rtl/wfs_flow_err.sv
module wfs_flow_err (
  input  logic clk,
  input  logic rst_n,
  input  logic ovf,
  input  logic udf,
  input  logic cmd_start,
  input  logic stat_rd,
  input  logic err_by_status,
  output logic flag
);
  logic clr;
  assign clr = err_by_status ? stat_rd : cmd_start;

  always_ff @(posedge clk) begin
    if (!rst_n)          flag <= 1'b0;
    else if (ovf || udf) flag <= 1'b1;
    else if (clr)        flag <= 1'b0;
  end

  // R10: a fresh error wins over any clear in the same cycle
  p_err_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf || udf) |=> flag);

  // R8: under the command policy only a command clears the flag
  p_cmd_policy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !err_by_status && !cmd_start) |=> flag);

  // R9: under the status policy only a status read clears the flag
  p_stat_policy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && err_by_status && !stat_rd) |=> flag);
endmodule

// File: rtl/wfifo_start_ctrl.sv
module wfifo_start_ctrl
  import wfs_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DEPTH = 32,
  parameter int LEN_W = 12,
  parameter int REG_W = 32,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr_en,
  input  logic [REG_W-1:0] cfg_wr_data,
  input  logic             cfg_wp_en,
  output logic [REG_W-1:0] cfg_rd_data,
  input  logic             cmd_start,
  input  logic [LEN_W-1:0] blk_len,
  input  logic             stat_rd,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [DW-1:0]    in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [DW-1:0]    out_data,
  output logic             xfer_start,
  output logic             flow_err,
  output logic [CW-1:0]    fill_count
);
  wfs_cfg_t cfg;
  logic     full, empty, wr_fire, rd_fire, ovf, udf;

  wfs_cfg_reg #(.REG_W(REG_W)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr_en),
    .wp_en   (cfg_wp_en),
    .wr_data (cfg_wr_data),
    .cfg     (cfg),
    .rd_data (cfg_rd_data)
  );

  wfs_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_req  (in_valid),
    .wr_data (in_data),
    .rd_req  (out_ready && xfer_start),
    .rd_data (out_data),
    .count   (fill_count),
    .full    (full),
    .empty   (empty),
    .wr_fire (wr_fire),
    .rd_fire (rd_fire),
    .ovf     (ovf)
  );

  wfs_start_ctl #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_start (
    .clk       (clk),
    .rst_n     (rst_n),
    .imm       (cfg.imm_start),
    .blk_len   (blk_len),
    .cmd_start (cmd_start),
    .fill      (fill_count),
    .wr_fire   (wr_fire),
    .rd_fire   (rd_fire),
    .start     (xfer_start)
  );

  assign udf       = xfer_start && out_ready && empty;
  assign in_ready  = !full;
  assign out_valid = xfer_start && !empty;

  wfs_flow_err u_err (
    .clk           (clk),
    .rst_n         (rst_n),
    .ovf           (ovf),
    .udf           (udf),
    .cmd_start     (cmd_start),
    .stat_rd       (stat_rd),
    .err_by_status (cfg.err_by_status),
    .flag          (flow_err)
  );

  // R13: a stalled card-side word stays offered and unchanged
  p_stall_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !cmd_start) |=> (out_valid && $stable(out_data)));

  // R7: pulling from an empty FIFO during a transfer raises the flag
  p_udf_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_start && out_ready && !out_valid) |=> flow_err);
endmodule

// File: tb/wfifo_start_ctrl_test.sv
module wfifo_start_ctrl_test;
  localparam int DW = 32, DEPTH = 32, LEN_W = 12, REG_W = 32;
  localparam int CW = $clog2(DEPTH) + 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_wr_en = 0, cfg_wp_en = 0, cmd_start = 0, stat_rd = 0;
  logic in_valid = 0, out_ready = 0;
  logic [REG_W-1:0] cfg_wr_data = '0, cfg_rd_data;
  logic [LEN_W-1:0] blk_len = '0;
  logic [DW-1:0] in_data = '0, out_data;
  logic in_ready, out_valid, xfer_start, flow_err;
  logic [CW-1:0] fill_count;
  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  wfifo_start_ctrl #(.DW(DW), .DEPTH(DEPTH), .LEN_W(LEN_W), .REG_W(REG_W)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .cfg_wp_en(cfg_wp_en), .cfg_rd_data(cfg_rd_data), .cmd_start(cmd_start),
    .blk_len(blk_len), .stat_rd(stat_rd), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .xfer_start(xfer_start), .flow_err(flow_err), .fill_count(fill_count)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_cfg(input logic [31:0] v, input logic wp);
    cfg_wr_data = v; cfg_wp_en = wp; cfg_wr_en = 1;
    @(posedge clk); @(negedge clk);
    cfg_wr_en = 0; cfg_wp_en = 0;
  endtask

  task automatic cmd(input int len);
    blk_len = LEN_W'(len); cmd_start = 1;
    @(posedge clk); @(negedge clk);
    cmd_start = 0;
  endtask

  task automatic push(input logic [31:0] d);
    in_valid = 1; in_data = d;
    @(posedge clk); @(negedge clk);
    in_valid = 0;
  endtask

  task automatic pull(input string tag, input logic [31:0] exp);
    chk({tag, " out_valid"}, 32'(out_valid), 32'd1);
    chk({tag, " order"}, out_data, exp);
    out_ready = 1;
    @(posedge clk); @(negedge clk);
    out_ready = 0;
  endtask

  task automatic t_reset;
    chk("R11 reset cfg", cfg_rd_data, 32'h0);
    chk("R5 reset start", 32'(xfer_start), 32'd0);
    chk("R8 reset flag", 32'(flow_err), 32'd0);
    chk("R13 reset ready", 32'(in_ready), 32'd1);
    chk("R13 reset fill", 32'(fill_count), 32'd0);
  endtask

  task automatic t_cfg;
    set_cfg(32'hFFFF_FFFF, 1'b0);
    chk("R11 field map", cfg_rd_data, 32'h0000_1111);
    set_cfg(32'h0, 1'b1);
    chk("R12 protected write", cfg_rd_data, 32'h0000_1111);
    set_cfg(32'h0, 1'b0);
    chk("R11 clear", cfg_rd_data, 32'h0);
  endtask

  task automatic t_half;
    cmd(24);
    for (int i = 0; i < 15; i++) push(32'h100 + i);
    step(2);
    chk("R1 below half", 32'(xfer_start), 32'd0);
    push(32'h10F);
    step(1);
    chk("R1 at half", 32'(xfer_start), 32'd1);
    for (int i = 16; i < 24; i++) push(32'h100 + i);
    for (int i = 0; i < 23; i++) pull("R13 half", 32'h100 + i);
    chk("R5 holds before last", 32'(xfer_start), 32'd1);
    pull("R13 half", 32'h117);
    chk("R5 falls after block", 32'(xfer_start), 32'd0);
    chk("R13 drained", 32'(out_valid), 32'd0);
  endtask

  task automatic t_quarter;
    cmd(16);
    for (int i = 0; i < 7; i++) push(32'h200 + i);
    step(2);
    chk("R2 below quarter", 32'(xfer_start), 32'd0);
    push(32'h207);
    step(1);
    chk("R2 at quarter", 32'(xfer_start), 32'd1);
    for (int i = 8; i < 16; i++) push(32'h200 + i);
    for (int i = 0; i < 16; i++) pull("R13 quarter", 32'h200 + i);
    chk("R5 quarter done", 32'(xfer_start), 32'd0);
  endtask

  task automatic t_whole;
    cmd(10);
    for (int i = 0; i < 9; i++) push(32'h300 + i);
    step(2);
    chk("R3 short block waits", 32'(xfer_start), 32'd0);
    push(32'h309);
    step(1);
    chk("R3 whole block in", 32'(xfer_start), 32'd1);
    for (int i = 0; i < 10; i++) pull("R13 whole", 32'h300 + i);
  endtask

  task automatic t_imm;
    set_cfg(32'h1, 1'b0);
    cmd(20);
    step(2);
    chk("R4 empty no start", 32'(xfer_start), 32'd0);
    push(32'h400);
    step(1);
    chk("R4 one word starts", 32'(xfer_start), 32'd1);
    for (int i = 1; i < 20; i++) push(32'h400 + i);
    for (int i = 0; i < 20; i++) pull("R13 imm", 32'h400 + i);
    chk("R5 imm done", 32'(xfer_start), 32'd0);
    push(32'h4FF);
    step(2);
    chk("R5 no rearm without cmd", 32'(xfer_start), 32'd0);
    cmd(20);
    step(1);
    chk("R5 rearm on cmd", 32'(xfer_start), 32'd1);
    pull("R13 imm tail", 32'h4FF);
  endtask

  task automatic t_underflow;
    cmd(2);
    push(32'h500);
    step(1);
    pull("R13 udf", 32'h500);
    chk("R7 no flag yet", 32'(flow_err), 32'd0);
    out_ready = 1;
    @(posedge clk); @(negedge clk);
    out_ready = 0;
    chk("R7 underflow flag", 32'(flow_err), 32'd1);
    stat_rd = 1;
    @(posedge clk); @(negedge clk);
    stat_rd = 0;
    chk("R8 status read ignored", 32'(flow_err), 32'd1);
    cmd(2);
    chk("R8 cleared by cmd", 32'(flow_err), 32'd0);
  endtask

  task automatic t_overflow;
    set_cfg(32'h11, 1'b0);
    cmd(40);
    for (int i = 0; i < 32; i++) push(32'h600 + i);
    chk("R13 full not ready", 32'(in_ready), 32'd0);
    chk("R6 fill at depth", 32'(fill_count), 32'd32);
    push(32'hDEAD);
    chk("R6 overflow flag", 32'(flow_err), 32'd1);
    chk("R6 fill unchanged", 32'(fill_count), 32'd32);
    cmd(40);
    chk("R9 cmd ignored", 32'(flow_err), 32'd1);
    stat_rd = 1;
    @(posedge clk); @(negedge clk);
    stat_rd = 0;
    chk("R9 cleared by status", 32'(flow_err), 32'd0);
    for (int i = 0; i < 32; i++) pull("R6 dropped word absent", 32'h600 + i);
    chk("R5 long block still on", 32'(xfer_start), 32'd1);
  endtask

  task automatic t_priority;
    stat_rd = 1; out_ready = 1;
    @(posedge clk); @(negedge clk);
    stat_rd = 0; out_ready = 0;
    chk("R10 error beats status clear", 32'(flow_err), 32'd1);
    stat_rd = 1;
    @(posedge clk); @(negedge clk);
    stat_rd = 0;
    chk("R9 clear again", 32'(flow_err), 32'd0);
    set_cfg(32'h1, 1'b0);
    blk_len = LEN_W'(40); cmd_start = 1; out_ready = 1;
    @(posedge clk); @(negedge clk);
    cmd_start = 0; out_ready = 0;
    chk("R10 error beats cmd clear", 32'(flow_err), 32'd1);
    cmd(40);
    chk("R8 cmd clears", 32'(flow_err), 32'd0);
  endtask

  initial begin
    step(3);
    rst_n = 1;
    step(1);
    t_reset;
    t_cfg;
    t_half;
    t_quarter;
    t_whole;
    t_imm;
    t_underflow;
    t_overflow;
    t_priority;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule